// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Framing

This block is an SPI master that moves a message of one or more 16-bit words between a host and a single serial slave. The host opens a message by handing over a word count and a clock divider setting. It then supplies one transmit word at a time over a valid/ready handshake. The block wraps every word in its own chip-select pulse. A message of N words therefore shows N separate low periods on the active-low select line, and each one carries exactly sixteen serial clocks.

The slave this block serves needs a setup time from select falling to the first serial clock edge, and it needs the select line toggled at every word boundary. The block meets both needs in hardware, so the timing does not depend on software. After chip-select falls, it waits at least two full serial clock periods before the first rising edge. Between words it keeps chip-select high for at least one full serial clock period. Signalling is fixed at SPI mode 0, most significant bit first. Each word shifted in from the slave is handed back with a single-cycle strobe.

Top module: `spiw_master`

## Requirements
- R1: While reset is applied, and at once when it is applied mid-transfer, chip-select is high, the serial clock and the serial data output are low, and busy and the receive strobe are low.
- R2: A message with a word count of N produces exactly N chip-select low periods. Each period contains exactly 16 rising serial clock edges, and chip-select returns high between consecutive words.
- R3: From chip-select going low to the first rising serial clock edge of that word, at least four half-periods pass, which is two full serial clock periods.
- R4: Before any falling edge of chip-select, the line has been high for at least two half-periods, which is one full serial clock period.
- R5: Mode 0 applies. The serial clock is low whenever chip-select is high. The data output changes only while the serial clock is low. The word sent is the accepted transmit word, bit 15 first.
- R6: One serial clock half-period lasts exactly D system clocks, where D is the divider input latched when the message is accepted. A divider value of 0 is treated as 1.
- R7: After each word, the receive data output holds the 16 bits sampled from the serial input on the rising serial clock edges, first sample in bit 15. The receive strobe is high for exactly one cycle per word.
- R8: Busy is high from the cycle after a message is accepted until the chip-select release that ends its last word. The request-ready output is the inverse of busy. A request made while busy, or a request with a word count of 0, starts nothing.
- R9: The transmit-ready output is high only while the block waits for the next word with chip-select high. A word is taken in the cycle where transmit-valid and transmit-ready are both high. The block waits as long as needed with chip-select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start-of-message request |
| req_ready_o | output | 1 | Block can accept a new message |
| req_len_i | input | LEN_W | Number of 16-bit words in the message |
| clk_div_i | input | DIV_W | Serial clock half-period in system clocks |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ready_o | output | 1 | Block takes the transmit word this cycle if valid |
| tx_data_i | input | WORD_W | Transmit word |
| rx_valid_o | output | 1 | One-cycle strobe: receive word complete |
| rx_data_o | output | WORD_W | Last received word |
| busy_o | output | 1 | Message in progress |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Chip-select, active low |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The embedded properties check the timing rules on every cycle: the clock is low while select is high, the output bit holds while the clock is high, the setup and gap windows are measured against the latched divider, each frame has sixteen rising edges, select is low only while busy, and the receive strobe lasts one cycle. Some results can only be seen in the bench scenarios, where a behavioural slave checks each frame against queued expectations. These are whether the transmitted and received word contents match bit for bit, whether an N-word message gives N frames, whether a zero divider really runs at one cycle per half-period, whether a stalled host keeps select high, and whether ignored requests and mid-word reset leave the pins as required.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_FETCH,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD
   } spiw_state_e;

endpackage

// File: rtl/spiw_tick.sv
module spiw_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = !clr_i && (cnt_q == half_i - DIV_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R6
   div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |-> (cnt_q < half_i));

endmodule

// File: rtl/spiw_shreg.sv
module spiw_shreg #(
   parameter int WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_data_i,
   input  logic              shift_i,
   input  logic              sample_i,
   input  logic              last_i,
   input  logic              miso_i,
   output logic              mosi_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              rx_valid_o
);

   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;

   assign mosi_o = tx_q[WORD_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q <= '0;
      end else if (load_i) begin
         tx_q <= load_data_i;
      end else if (shift_i) begin
         tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q       <= '0;
         rx_data_o  <= '0;
         rx_valid_o <= 1'b0;
      end else begin
         rx_valid_o <= sample_i && last_i;
         if (sample_i) begin
            rx_q <= {rx_q[WORD_W-2:0], miso_i};
         end
         if (sample_i && last_i) begin
            rx_data_o <= {rx_q[WORD_W-2:0], miso_i};
         end
      end
   end

   // R7
   rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_valid_o |=> !rx_valid_o);

endmodule

// File: rtl/spiw_master.sv
module spiw_master
   import spiw_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter int LEN_W        = 8,
   parameter int DIV_W        = 8,
   parameter int SETUP_HALVES = 4,
   parameter int GAP_HALVES   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [LEN_W-1:0]  req_len_i,
   input  logic [DIV_W-1:0]  clk_div_i,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   input  logic [WORD_W-1:0] tx_data_i,
   output logic              rx_valid_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              busy_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              cs_n_o,
   input  logic              miso_i
);

   localparam int HALF_MAX = (SETUP_HALVES > GAP_HALVES) ? SETUP_HALVES : GAP_HALVES;
   localparam int HC_W     = $clog2(HALF_MAX + 1);
   localparam int BIT_W    = $clog2(WORD_W + 1);
   localparam int MON_W    = DIV_W + HC_W + 1;
   localparam logic [HC_W-1:0]  SETUP_LAST = HC_W'(SETUP_HALVES - 1);
   localparam logic [HC_W-1:0]  GAP_LAST   = HC_W'(GAP_HALVES - 1);
   localparam logic [BIT_W-1:0] BITS_ALL   = BIT_W'(WORD_W);
   localparam logic [BIT_W-1:0] BITS_PEN   = BIT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spiw_master: WORD_W must be at least 2");
      end
      if (SETUP_HALVES < 4) begin : g_bad_setup
         $error("spiw_master: SETUP_HALVES must be at least 4");
      end
      if (GAP_HALVES < 2) begin : g_bad_gap
         $error("spiw_master: GAP_HALVES must be at least 2");
      end
      if (DIV_W < 1 || LEN_W < 1) begin : g_bad_width
         $error("spiw_master: DIV_W and LEN_W must be positive");
      end
   endgenerate

   spiw_state_e      state_q;
   logic [HC_W-1:0]  half_q;
   logic [BIT_W-1:0] bit_q;
   logic [LEN_W-1:0] left_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_eff;
   logic             sclk_q;
   logic             cs_n_q;
   logic             tick;
   logic             tick_clr;
   logic             load_w;
   logic             rise_w;
   logic             fall_w;
   logic             shift_w;
   logic             last_w;

   assign div_eff  = (clk_div_i == '0) ? DIV_W'(1) : clk_div_i;
   assign tick_clr = (state_q == ST_IDLE) || (state_q == ST_FETCH);
   assign load_w   = (state_q == ST_FETCH) && tx_valid_i;
   assign rise_w   = tick && (((state_q == ST_SETUP) && (half_q == SETUP_LAST)) ||
                              ((state_q == ST_SHIFT) && !sclk_q));
   assign fall_w   = tick && (state_q == ST_SHIFT) && sclk_q;
   assign shift_w  = fall_w && (bit_q != BITS_ALL);
   assign last_w   = (state_q == ST_SHIFT) && (bit_q == BITS_PEN);

   assign req_ready_o = (state_q == ST_IDLE);
   assign busy_o      = (state_q != ST_IDLE);
   assign tx_ready_o  = (state_q == ST_FETCH);
   assign sclk_o      = sclk_q;
   assign cs_n_o      = cs_n_q;

   spiw_tick #(.DIV_W(DIV_W)) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tick_clr),
      .half_i (div_q),
      .tick_o (tick)
   );

   spiw_shreg #(.WORD_W(WORD_W)) shreg_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_w),
      .load_data_i (tx_data_i),
      .shift_i     (shift_w),
      .sample_i    (rise_w),
      .last_i      (last_w),
      .miso_i      (miso_i),
      .mosi_o      (mosi_o),
      .rx_data_o   (rx_data_o),
      .rx_valid_o  (rx_valid_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         half_q  <= '0;
         bit_q   <= '0;
         left_q  <= '0;
         div_q   <= DIV_W'(1);
         sclk_q  <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i && (req_len_i != '0)) begin
                  left_q  <= req_len_i;
                  div_q   <= div_eff;
                  half_q  <= '0;
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (half_q == GAP_LAST) begin
                     half_q  <= '0;
                     state_q <= ST_FETCH;
                  end else begin
                     half_q <= half_q + HC_W'(1);
                  end
               end
            end
            ST_FETCH: begin
               if (tx_valid_i) begin
                  cs_n_q  <= 1'b0;
                  left_q  <= left_q - LEN_W'(1);
                  half_q  <= '0;
                  bit_q   <= '0;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (tick) begin
                  if (half_q == SETUP_LAST) begin
                     sclk_q  <= 1'b1;
                     bit_q   <= BIT_W'(1);
                     state_q <= ST_SHIFT;
                  end else begin
                     half_q <= half_q + HC_W'(1);
                  end
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (sclk_q) begin
                     sclk_q <= 1'b0;
                     if (bit_q == BITS_ALL) begin
                        state_q <= ST_HOLD;
                     end
                  end else begin
                     sclk_q <= 1'b1;
                     bit_q  <= bit_q + BIT_W'(1);
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  cs_n_q  <= 1'b1;
                  half_q  <= '0;
                  state_q <= (left_q == '0) ? ST_IDLE : ST_GAP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Timing monitors feeding the properties below
   logic [MON_W-1:0] cs_low_cyc;
   logic [MON_W-1:0] cs_high_cyc;
   logic [BIT_W-1:0] rise_cnt;
   logic             sclk_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_low_cyc  <= '0;
         cs_high_cyc <= '1;
         rise_cnt    <= '0;
         sclk_d      <= 1'b0;
      end else begin
         sclk_d <= sclk_o;
         if (cs_n_o) begin
            cs_low_cyc <= '0;
            rise_cnt   <= '0;
            if (cs_high_cyc != '1) cs_high_cyc <= cs_high_cyc + MON_W'(1);
         end else begin
            cs_high_cyc <= '0;
            if (cs_low_cyc != '1) cs_low_cyc <= cs_low_cyc + MON_W'(1);
            if (sclk_o && !sclk_d) rise_cnt <= rise_cnt + BIT_W'(1);
         end
      end
   end

   // R5
   idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n_o |-> !sclk_o);

   // R5
   mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclk_o && !$rose(sclk_o)) |-> $stable(mosi_o));

   // R3
   setup_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(sclk_o) && (rise_cnt == '0)) |->
         (cs_low_cyc >= MON_W'(SETUP_HALVES) * MON_W'(div_q)));

   // R4
   gap_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cs_n_o) |-> (cs_high_cyc >= MON_W'(GAP_HALVES) * MON_W'(div_q)));

   // R2
   word_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_n_o) |-> (rise_cnt == BITS_ALL));

   // R8
   busy_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_n_o |-> busy_o);

   // R9
   fetch_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ready_o |-> cs_n_o);

endmodule

// File: tb/spiw_master_tb.sv
`timescale 1ns/1ps
module spiw_master_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_len = '0;
   logic [7:0]  clk_div = '0;
   logic        tx_valid = 1'b0;
   logic [15:0] tx_data = '0;
   logic        miso = 1'b0;
   logic        req_ready_o, tx_ready_o, rx_valid_o, busy_o, sclk_o, mosi_o, cs_n_o;
   logic [15:0] rx_data_o;

   always #2.5 clk = ~clk;

   spiw_master dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready_o),
      .req_len_i   (req_len),
      .clk_div_i   (clk_div),
      .tx_valid_i  (tx_valid),
      .tx_ready_o  (tx_ready_o),
      .tx_data_i   (tx_data),
      .rx_valid_o  (rx_valid_o),
      .rx_data_o   (rx_data_o),
      .busy_o      (busy_o),
      .sclk_o      (sclk_o),
      .mosi_o      (mosi_o),
      .cs_n_o      (cs_n_o),
      .miso_i      (miso)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural slave and pin reference model, evaluated every cycle
   logic [15:0] tx_q[$];
   logic [15:0] slv_q[$];
   logic [15:0] rxe_q[$];
   int          frames = 0;
   int          rx_cnt = 0;
   int          bitn = 0;
   int          cyc_low = 0;
   int          cyc_high = 100000;
   int          half_len = 0;
   int          div_eff = 1;
   logic        prev_cs = 1'b1;
   logic        prev_sclk = 1'b0;
   logic        prev_mosi = 1'b0;
   logic [15:0] sw = '0;
   logic [15:0] cap = '0;
   logic [15:0] expw;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_cs   = 1'b1;
         prev_sclk = 1'b0;
         prev_mosi = 1'b0;
         bitn      = 0;
         cyc_high  = 100000;
         half_len  = 0;
         miso      = 1'b0;
      end else begin
         cyc_low++;
         cyc_high++;
         half_len++;
         if (prev_cs && !cs_n_o) begin
            chk(cyc_high >= 2 * div_eff, "R4 cs high gap", cyc_high, 2 * div_eff);
            frames++;
            cyc_low  = 0;
            half_len = 0;
            bitn     = 0;
            cap      = '0;
            sw       = (slv_q.size() > 0) ? slv_q.pop_front() : 16'hFFFF;
            rxe_q.push_back(sw);
            miso     = sw[15];
         end
         if (!cs_n_o) chk(busy_o, "R8 busy during frame", busy_o, 1);
         if (!prev_sclk && sclk_o) begin
            if (bitn == 0) chk(cyc_low >= 4 * div_eff, "R3 setup", cyc_low, 4 * div_eff);
            else chk(half_len == div_eff, "R6 low half", half_len, div_eff);
            cap      = {cap[14:0], mosi_o};
            bitn++;
            half_len = 0;
         end else if (prev_sclk && !sclk_o) begin
            chk(half_len == div_eff, "R6 high half", half_len, div_eff);
            half_len = 0;
            if (bitn < 16) miso = sw[15 - bitn];
         end else if (sclk_o) begin
            chk(mosi_o == prev_mosi, "R5 mosi stable", mosi_o, prev_mosi);
         end
         if (!prev_cs && cs_n_o) begin
            chk(bitn == 16, "R2 edges per frame", bitn, 16);
            expw = (tx_q.size() > 0) ? tx_q.pop_front() : 16'hDEAD;
            chk(cap == expw, "R5 mosi word", cap, expw);
            cyc_high = 0;
         end
         if (cs_n_o) chk(!sclk_o, "R5 sclk idle", sclk_o, 0);
         if (rx_valid_o) begin
            expw = (rxe_q.size() > 0) ? rxe_q.pop_front() : 16'hBEEF;
            chk(rx_data_o == expw, "R7 rx word", rx_data_o, expw);
            rx_cnt++;
         end
         prev_cs   = cs_n_o;
         prev_sclk = sclk_o;
         prev_mosi = mosi_o;
      end
   end

   task automatic wait_idle();
      int n = 0;
      while (busy_o && n < 40000) begin
         @(negedge clk);
         n++;
      end
      chk(!busy_o, "R8 busy clears", busy_o, 0);
   endtask

   task automatic send_word(input logic [15:0] w);
      tx_q.push_back(w);
      tx_valid = 1'b1;
      tx_data  = w;
      while (!tx_ready_o) @(negedge clk);
      chk(cs_n_o, "R9 ready with cs high", cs_n_o, 1);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic run_msg(input int len, input int dv, input int stall_word,
                          input int stall_cyc, input bit poke);
      int f0 = frames;
      int r0 = rx_cnt;
      div_eff = (dv == 0) ? 1 : dv;
      for (int k = 0; k < len; k++)
         slv_q.push_back(16'(16'hC3A5 ^ (k * 16'h1357) ^ (dv << 8)));
      @(negedge clk);
      chk(req_ready_o, "R8 ready when idle", req_ready_o, 1);
      req_valid = 1'b1;
      req_len   = 8'(len);
      clk_div   = 8'(dv);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy_o && !req_ready_o, "R8 busy after accept", busy_o, 1);
      if (poke) begin
         req_valid = 1'b1;
         req_len   = 8'd5;
         chk(!req_ready_o, "R8 not ready while busy", req_ready_o, 0);
         @(negedge clk);
         req_valid = 1'b0;
      end
      for (int k = 0; k < len; k++) begin
         if (k == stall_word) begin
            for (int s = 0; s < stall_cyc; s++) begin
               @(negedge clk);
               if (tx_ready_o) chk(cs_n_o, "R9 cs high while waiting", cs_n_o, 1);
            end
         end
         send_word(16'(16'h8001 + k * 16'h2345 + len * 16'h0101 + dv));
      end
      wait_idle();
      repeat (2) @(negedge clk);
      chk(frames - f0 == len, "R2 frame count", frames - f0, len);
      chk(rx_cnt - r0 == len, "R7 rx count", rx_cnt - r0, len);
      chk(cs_n_o && !sclk_o, "R5 idle pins", {cs_n_o, sclk_o}, 2'b10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(cs_n_o && !sclk_o && !mosi_o && !busy_o && !rx_valid_o, "R1 reset pins",
          {cs_n_o, sclk_o, mosi_o, busy_o, rx_valid_o}, 5'b10000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_msg(1, 1, -1, 0, 1'b0);
      run_msg(3, 2, -1, 0, 1'b0);
      // R6 divider zero behaves as one
      run_msg(2, 0, -1, 0, 1'b0);
      run_msg(2, 5, -1, 0, 1'b0);
      // R9 host stall between words
      run_msg(3, 1, 1, 60, 1'b0);
      // R8 request during busy is ignored
      run_msg(1, 3, -1, 0, 1'b1);

      // R8 zero-length request starts nothing
      @(negedge clk);
      req_valid = 1'b1;
      req_len   = 8'd0;
      clk_div   = 8'd2;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 10; i++) begin
         chk(!busy_o && cs_n_o && !tx_ready_o, "R8 zero length ignored",
             {busy_o, cs_n_o, tx_ready_o}, 3'b010);
         @(negedge clk);
      end

      // R1 reset in the middle of a word
      div_eff = 4;
      slv_q.push_back(16'h5AA5);
      slv_q.push_back(16'hA55A);
      @(negedge clk);
      req_valid = 1'b1;
      req_len   = 8'd2;
      clk_div   = 8'd4;
      @(negedge clk);
      req_valid = 1'b0;
      send_word(16'hF00F);
      begin
         int n = 0;
         while (bitn < 5 && n < 2000) begin
            @(negedge clk);
            n++;
         end
      end
      rst_n = 1'b0;
      #1;
      chk(cs_n_o && !sclk_o && !mosi_o && !busy_o, "R1 reset mid-word",
          {cs_n_o, sclk_o, mosi_o, busy_o}, 4'b1000);
      tx_q.delete();
      slv_q.delete();
      rxe_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && req_ready_o, "R1 idle after reset", busy_o, 0);
      run_msg(2, 2, -1, 0, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule